// File: doc/BRIEF.md
# Direct I/O Command Sequencer

This block is the I/O-processor control logic that turns one CPU direct I/O request into exactly one handshaked cycle on the device bus. The CPU presents a command word with a 2-bit command code, a 7-bit device number and, for output commands, a data word. The sequencer then raises service-out. While service-out is high it drives the code onto the command lines and the number onto the device lines, and it drives the data lines for output commands. It then waits for the addressed device to answer with service-in.

For input commands, the word on the device data lines is captured into a data-in register when service-in is seen, and a word-ready flag tells the CPU that the word is waiting. The word appears on the CPU internal bus only while the CPU holds its read strobe. Service-out drops once service-in is seen, and the sequencer goes idle once service-in falls. If no device answers within the timeout window, the cycle is abandoned and a timeout flag is set. While a cycle is in progress the block reports busy, and it refuses new commands.

Top module: `dio_seq`

## Requirements
- R1: After reset, service-out, busy, word-ready and the timeout flag are all low, and the CPU bus output is zero.
- R2: A command presented with `cmd_valid_i` while `busy_o` is low is accepted at that clock edge. From the next cycle, `bus_so_o` and `busy_o` are high, `bus_cmd_o` carries the code and `bus_dev_o` carries the device number.
- R3: A command presented while `busy_o` is high is ignored. The command and device lines keep the accepted values, and no second bus cycle follows.
- R4: Codes are Test=00, Control=01, Read=10, Write=11. For Control and Write (bit 0 set), `bus_dout_en_o` is high and `bus_dout_o` carries the CPU word for every cycle of service-out. For Test and Read, `bus_dout_en_o` is low and `bus_dout_o` is zero.
- R5: When `bus_si_i` is sampled high during service-out, service-out is low in the next cycle and busy stays high. The sequencer becomes idle (busy low) the cycle after `bus_si_i` is sampled low.
- R6: For Test and Read, the clock edge that samples service-in loads `bus_din_i` into the data-in register and sets `word_rdy_o`. Control and Write leave the register and the flag unchanged.
- R7: `sbus_o` equals the data-in register while `rd_i` is high, and it is zero otherwise. A clock edge with `rd_i` high clears `word_rdy_o`.
- R8: When a load and a read strobe fall on the same edge, the load wins. `word_rdy_o` stays high and the new word is kept, while `sbus_o` shows the old word during that strobe.
- R9: If service-in does not arrive, service-out stays high for exactly `TMO_CYC` (64) cycles and then drops. At that point `tmo_err_o` is set and `busy_o` is low, and the data-in register and word-ready are untouched.
- R10: `tmo_err_o` stays set until the next command is accepted, and it clears at that acceptance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | CPU presents a command word |
| cmd_code_i | input | 2 | Command code |
| cmd_dev_i | input | 7 | Device number |
| cmd_wdata_i | input | 16 | Output data word |
| busy_o | output | 1 | Cycle in progress, commands refused |
| tmo_err_o | output | 1 | Last cycle ended without service-in |
| bus_so_o | output | 1 | Service-out |
| bus_cmd_o | output | 2 | Command lines |
| bus_dev_o | output | 7 | Device number lines |
| bus_dout_o | output | 16 | Data lines driven toward device |
| bus_dout_en_o | output | 1 | Data lines driven by this block |
| bus_si_i | input | 1 | Service-in from device |
| bus_din_i | input | 16 | Data lines from device |
| word_rdy_o | output | 1 | Data-in register holds an unread word |
| rd_i | input | 1 | CPU read strobe |
| sbus_o | output | 16 | CPU internal bus output |

## Verification
A CPU read strobe that clears word-ready can land on the same edge as a service-in that reloads the data-in register. This happens when the CPU starts a new Test or Read before it has read the previous word. The bench provokes this on purpose: it raises `rd_i` in the same cycle as `bus_si_i`, and it also does so at random points. It judges the outcome against its own word model. During that strobe `sbus_o` must still show the old word, and afterwards word-ready must stay set and a following read must return the new word.

// File: rtl/dio_pkg.sv
package dio_pkg;
  typedef enum logic [1:0] {
    CMD_TEST  = 2'b00,
    CMD_CTRL  = 2'b01,
    CMD_READ  = 2'b10,
    CMD_WRITE = 2'b11
  } dio_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_SO   = 2'b01,
    ST_REL  = 2'b10
  } dio_state_e;

  // bit 0 of the code marks commands that drive data to the device
  function automatic logic is_output(input logic [1:0] code);
    return code[0];
  endfunction
endpackage

// File: rtl/dio_tmo.sv
module dio_tmo #(
  parameter int TMO_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic hit_o
);
  localparam int CW = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (!hit_o) cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/dio_fsm.sv
module dio_fsm
  import dio_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic       si_i,
  input  logic       tmo_hit_i,
  output dio_state_e state_o,
  output logic       accept_o,
  output logic       abort_o,
  output logic       done_o
);
  dio_state_e state_q, state_d;

  assign accept_o = (state_q == ST_IDLE) && cmd_valid_i;
  assign done_o   = (state_q == ST_SO) && si_i;
  assign abort_o  = (state_q == ST_SO) && !si_i && tmo_hit_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (cmd_valid_i) state_d = ST_SO;
      ST_SO: begin
        if (si_i)           state_d = ST_REL;
        else if (tmo_hit_i) state_d = ST_IDLE;
      end
      ST_REL:  if (!si_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/dio_din_reg.sv
module dio_din_reg #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] din_i,
  input  logic          rd_i,
  output logic          rdy_o,
  output logic [DW-1:0] sbus_o
);
  logic [DW-1:0] data_q;
  logic          rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      rdy_q  <= 1'b0;
    end else begin
      if (load_i) data_q <= din_i;
      // load takes priority over the read clear
      if (load_i)    rdy_q <= 1'b1;
      else if (rd_i) rdy_q <= 1'b0;
    end
  end

  assign rdy_o  = rdy_q;
  assign sbus_o = rd_i ? data_q : '0;
endmodule

// File: rtl/dio_seq.sv
module dio_seq
  import dio_pkg::*;
#(
  parameter int DW      = 16,
  parameter int AW      = 7,
  parameter int TMO_CYC = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_code_i,
  input  logic [AW-1:0] cmd_dev_i,
  input  logic [DW-1:0] cmd_wdata_i,
  output logic          busy_o,
  output logic          tmo_err_o,
  output logic          bus_so_o,
  output logic [1:0]    bus_cmd_o,
  output logic [AW-1:0] bus_dev_o,
  output logic [DW-1:0] bus_dout_o,
  output logic          bus_dout_en_o,
  input  logic          bus_si_i,
  input  logic [DW-1:0] bus_din_i,
  output logic          word_rdy_o,
  input  logic          rd_i,
  output logic [DW-1:0] sbus_o
);
  dio_state_e    state;
  logic          accept, abort, done, tmo_hit, so;
  logic [1:0]    code_q;
  logic [AW-1:0] dev_q;
  logic [DW-1:0] wdata_q;
  logic          tmo_q;

  dio_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .si_i        (bus_si_i),
    .tmo_hit_i   (tmo_hit),
    .state_o     (state),
    .accept_o    (accept),
    .abort_o     (abort),
    .done_o      (done)
  );

  assign so = (state == ST_SO);

  dio_tmo #(.TMO_CYC(TMO_CYC)) u_tmo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (so),
    .hit_o  (tmo_hit)
  );

  dio_din_reg #(.DW(DW)) u_din (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (done && !is_output(code_q)),
    .din_i  (bus_din_i),
    .rd_i   (rd_i),
    .rdy_o  (word_rdy_o),
    .sbus_o (sbus_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= '0;
      dev_q   <= '0;
      wdata_q <= '0;
      tmo_q   <= 1'b0;
    end else begin
      if (accept) begin
        code_q  <= cmd_code_i;
        dev_q   <= cmd_dev_i;
        wdata_q <= cmd_wdata_i;
      end
      if (accept)     tmo_q <= 1'b0;
      else if (abort) tmo_q <= 1'b1;
    end
  end

  assign busy_o        = (state != ST_IDLE);
  assign tmo_err_o     = tmo_q;
  assign bus_so_o      = so;
  assign bus_cmd_o     = so ? code_q : '0;
  assign bus_dev_o     = so ? dev_q : '0;
  assign bus_dout_en_o = so && is_output(code_q);
  assign bus_dout_o    = bus_dout_en_o ? wdata_q : '0;
endmodule

// File: rtl/dio_seq_chk.sv
module dio_seq_chk #(
  parameter int DW      = 16,
  parameter int AW      = 7,
  parameter int TMO_CYC = 64
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_i,
  input logic [1:0]    cmd_code_i,
  input logic          busy_o,
  input logic          tmo_err_o,
  input logic          bus_so_o,
  input logic [1:0]    bus_cmd_o,
  input logic [AW-1:0] bus_dev_o,
  input logic [DW-1:0] bus_dout_o,
  input logic          bus_dout_en_o,
  input logic          bus_si_i,
  input logic          word_rdy_o,
  input logic          rd_i
);
  localparam int CW = $clog2(TMO_CYC + 1) + 1;
  logic [CW-1:0] so_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       so_run_q <= '0;
    else if (bus_so_o) so_run_q <= so_run_q + 1'b1;
    else               so_run_q <= '0;
  end

  // R2
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !busy_o |=> bus_so_o && busy_o && bus_cmd_o == $past(cmd_code_i));

  // R3
  hold_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_so_o |=> !bus_so_o || ($stable(bus_cmd_o) && $stable(bus_dev_o)));

  // R4
  dout_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_dout_en_o == (bus_so_o && bus_cmd_o[0]));

  // R4
  dout_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_dout_en_o |-> bus_dout_o == '0);

  // R5
  so_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_so_o && bus_si_i |=> !bus_so_o && busy_o);

  // R6
  load_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_so_o && bus_si_i && !bus_cmd_o[0] |=> word_rdy_o);

  // R7
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !(bus_so_o && bus_si_i && !bus_cmd_o[0]) |=> !word_rdy_o);

  // R9
  so_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_so_o |-> so_run_q < CW'(TMO_CYC));

  // R9
  tmo_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmo_err_o) |-> !busy_o && $past(bus_so_o));
endmodule

bind dio_seq dio_seq_chk #(.DW(DW), .AW(AW), .TMO_CYC(TMO_CYC)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_valid_i   (cmd_valid_i),
  .cmd_code_i    (cmd_code_i),
  .busy_o        (busy_o),
  .tmo_err_o     (tmo_err_o),
  .bus_so_o      (bus_so_o),
  .bus_cmd_o     (bus_cmd_o),
  .bus_dev_o     (bus_dev_o),
  .bus_dout_o    (bus_dout_o),
  .bus_dout_en_o (bus_dout_en_o),
  .bus_si_i      (bus_si_i),
  .word_rdy_o    (word_rdy_o),
  .rd_i          (rd_i)
);

// File: tb/sim_dio_seq.sv
`timescale 1ns/1ps
module sim_dio_seq;
  localparam int DW = 16, AW = 7, TMO = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, si = 0, rd = 0;
  logic [1:0] code = 0;
  logic [AW-1:0] dev = 0;
  logic [DW-1:0] wdata = 0, din = 0;
  logic busy, tmo_err, so, dout_en, word_rdy;
  logic [1:0] bcmd;
  logic [AW-1:0] bdev;
  logic [DW-1:0] dout, sbus;

  int total = 0, bad = 0;
  bit exp_rdy = 0;
  logic [DW-1:0] exp_reg = '0;

  always #2 clk = ~clk;

  dio_seq #(.DW(DW), .AW(AW), .TMO_CYC(TMO)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_code_i(code),
    .cmd_dev_i(dev), .cmd_wdata_i(wdata), .busy_o(busy), .tmo_err_o(tmo_err),
    .bus_so_o(so), .bus_cmd_o(bcmd), .bus_dev_o(bdev), .bus_dout_o(dout),
    .bus_dout_en_o(dout_en), .bus_si_i(si), .bus_din_i(din), .word_rdy_o(word_rdy),
    .rd_i(rd), .sbus_o(sbus)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h @%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] exp_dout(input logic [1:0] c, input logic [DW-1:0] w);
    return c[0] ? w : '0;
  endfunction

  task automatic issue(input logic [1:0] c, input logic [AW-1:0] d, input logic [DW-1:0] w);
    @(negedge clk);
    cmd_valid = 1; code = c; dev = d; wdata = w;
    @(negedge clk);
    cmd_valid = 0; code = ~c; dev = ~d; wdata = ~w;
    #1;
    chk("R2 so", so, 1); chk("R2 busy", busy, 1);
    chk("R2 cmd", bcmd, c); chk("R2 dev", bdev, d);
    chk("R10 tmo clear", tmo_err, 0);
    chk("R4 en", dout_en, c[0]); chk("R4 dout", dout, exp_dout(c, w));
  endtask

  // device answers after dly extra cycles; optional read strobe in the si cycle
  task automatic answer(input logic [1:0] c, input logic [AW-1:0] d, input logic [DW-1:0] w,
                        input int dly, input logic [DW-1:0] dv, input bit rd_same);
    for (int k = 0; k < dly; k++) begin
      @(negedge clk); #1;
      chk("R4 hold", dout, exp_dout(c, w)); chk("R3 dev hold", bdev, d);
    end
    @(negedge clk);
    si = 1; din = dv; rd = rd_same;
    #1;
    if (rd_same) chk("R8 old word on sbus", sbus, exp_reg);
    @(negedge clk);
    si = 0; rd = 0; din = ~dv;
    if (rd_same) exp_rdy = 0;
    if (!c[0]) begin exp_reg = dv; exp_rdy = 1; end
    #1;
    chk("R5 so low", so, 0); chk("R5 busy held", busy, 1);
    chk("R6/R8 word_rdy", word_rdy, exp_rdy);
    @(negedge clk); #1;
    chk("R5 idle", busy, 0);
  endtask

  task automatic read_word();
    @(negedge clk);
    rd = 1; #1;
    chk("R7 sbus", sbus, exp_reg);
    @(negedge clk);
    rd = 0; exp_rdy = 0; #1;
    chk("R7 rdy clear", word_rdy, 0); chk("R7 sbus idle", sbus, 0);
  endtask

  initial begin
    #1;
    chk("R1 so", so, 0); chk("R1 busy", busy, 0); chk("R1 rdy", word_rdy, 0);
    chk("R1 tmo", tmo_err, 0); chk("R1 sbus", sbus, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;

    // directed: each code once
    issue(2'b00, 7'h05, 16'h1111); answer(2'b00, 7'h05, 16'h1111, 2, 16'hA5A5, 0);
    issue(2'b11, 7'h7F, 16'hBEEF); answer(2'b11, 7'h7F, 16'hBEEF, 0, 16'h0F0F, 0);
    issue(2'b01, 7'h00, 16'h0003); answer(2'b01, 7'h00, 16'h0003, 1, 16'h3333, 0);
    read_word();
    issue(2'b10, 7'h2A, 16'h0); answer(2'b10, 7'h2A, 16'h0, 3, 16'h1234, 0);

    // R8: read strobe in same cycle as a new load
    issue(2'b00, 7'h11, 16'h0); answer(2'b00, 7'h11, 16'h0, 1, 16'h5678, 1);
    read_word();

    // R3: command while busy
    issue(2'b10, 7'h33, 16'h0);
    @(negedge clk);
    cmd_valid = 1; code = 2'b11; dev = 7'h44; wdata = 16'hFFFF;
    @(negedge clk);
    cmd_valid = 0; #1;
    chk("R3 cmd kept", bcmd, 2'b10); chk("R3 dev kept", bdev, 7'h33);
    chk("R3 no drive", dout_en, 0);
    answer(2'b10, 7'h33, 16'h0, 0, 16'h9999, 0);
    @(negedge clk); #1;
    chk("R3 no second cycle", so, 0);

    // R9: timeout
    begin
      int n = 0;
      issue(2'b10, 7'h40, 16'h0);
      for (int k = 0; k < 200; k++) begin
        if (!so) break;
        n++;
        @(negedge clk); #1;
      end
      chk("R9 so cycles", n, TMO);
      chk("R9 tmo set", tmo_err, 1); chk("R9 idle", busy, 0);
      chk("R9 rdy untouched", word_rdy, exp_rdy);
      repeat (2) @(negedge clk);
      #1 chk("R10 tmo held", tmo_err, 1);
      issue(2'b01, 7'h41, 16'h7777); answer(2'b01, 7'h41, 16'h7777, 0, 16'h0, 0);
      read_word();
    end

    // constrained random
    begin
      int unsigned seed = $urandom(32'd2024);
      for (int i = 0; i < 60; i++) begin
        logic [1:0] c = 2'($urandom);
        logic [AW-1:0] d = AW'($urandom);
        logic [DW-1:0] w = DW'($urandom);
        logic [DW-1:0] v = DW'($urandom);
        int dl = int'($urandom % 12);
        bit rs = ($urandom % 4) == 0;
        issue(c, d, w);
        answer(c, d, w, dl, v, rs);
        if ($urandom % 3 == 0) read_word();
      end
      seed = seed + 1;
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule